// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot

This block is a real-time calendar core for a large chip. A one-hertz tick input drives a chain of packed-BCD counters: seconds, minutes, hours (24-hour only), day of month, month, two-digit year, and a separate day-of-week counter. Host software reaches the block through a byte-wide register bus. The bus has an address, write data, a write strobe and combinational read data.

Counting runs only while a run bit in the control byte is set. Software clears that bit, loads new time values, then sets it again. The host never reads the live counters. Every read of a time offset returns a set of static latches. A self-clearing snapshot bit in the control byte copies all the live counters into those latches in one step, so the time that software reads is always consistent. Two more control bits, for hour format and for rounding, are kept for software but have no effect on the count.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the clock is stopped. Reads of offsets 0x00 to 0x06 return 0x00, 0x00, 0x00, 0x01, 0x01, 0x00, 0x00 (seconds, minutes, hours, day, month, year, day of week). The control byte at 0x08 and the status byte at 0x09 both read 0x00.
- R2: The time fields are at offsets 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (day of month), 0x04 (month), 0x05 (year) and 0x06 (day of week). The control byte is at 0x08 and the status byte at 0x09. All other offsets read 0x00.
- R3: While running, each tick advances seconds in packed BCD. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00 and carry into the day.
- R4: The day of month rolls from the last day of the month to 01 and carries into the month. The last day is 31, 30 for months 04, 06, 09 and 11, and 28 for month 02, or 29 when the year value is divisible by 4. The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R5: The day of week counts 00 to 06. It advances at every day rollover and goes from 06 to 00.
- R6: Control bit 0 is the run bit. While it is 0, ticks are ignored. Status bit 1 always equals the run bit, and the other status bits read 0.
- R7: Writing control with bit 6 set copies the live counters into the read latches at the next clock edge. Bit 6 reads 1 in the single cycle after that write and 0 afterwards. Time reads return the latched copy, which does not change until the next snapshot.
- R8: A write to a time offset takes effect whether the clock is running or not. A tick in the same cycle as any time-offset write is discarded, so fields that are not written keep their values.
- R9: Control bits 1 and 3 are stored and read back. They change neither the 24-hour count nor the seconds value. The other control bits, except bit 6, read 0.
- R10: Writes to the status byte or to unused offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W (5) | Register offset |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one write per cycle |
| rdData | output | 8 | Read data for `addr`, combinational |

## Verification
The hardest behaviours to reach from the ports are the long carry cascades: year end, leap-day February and the short months. Each needs every lower field at its terminal value at the same moment. The bench gets there by stopping the clock and loading the fields just before a rollover, then ticking, and random iterations favour near-terminal values for the same reason. Two other cases need care. A tick that lands in the same cycle as a field write is driven in one bus cycle. Snapshot staleness is shown by ticking after a snapshot and reading before taking a new one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_N = 7;
  localparam int BCD_W = 8;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_WDAY = 6;

  typedef struct packed {
    logic [FIELD_N-1:0] fieldWr;
    logic [BCD_W-1:0]   wrValue;
    logic               step;
    logic               snap;
  } strobes_t;

  function automatic logic [BCD_W-1:0] bcdNext(input logic [BCD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [BCD_W-1:0] fieldFirst(input int i);
    return (i == IDX_DAY || i == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [BCD_W-1:0] fieldLastFixed(input int i);
    case (i)
      IDX_SEC, IDX_MIN: return 8'h59;
      IDX_HOUR:         return 8'h23;
      IDX_MON:          return 8'h12;
      IDX_YEAR:         return 8'h99;
      IDX_WDAY:         return 8'h06;
      default:          return 8'h31;
    endcase
  endfunction

  function automatic logic [BCD_W-1:0] monthLast(input logic [BCD_W-1:0] mon,
                                                 input logic [BCD_W-1:0] yr);
    logic [1:0] rem;
    rem = yr[1:0] + {yr[4], 1'b0};
    case (mon)
      8'h02:                      return (rem == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 8,
  parameter int STATUS_ADDR = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BCD_W-1:0]         wrData,
  input  logic                     wrEn,
  input  logic [FIELD_N*BCD_W-1:0] shadowFlat,
  output strobes_t                 strobes,
  output logic                     runBit,
  output logic [BCD_W-1:0]         rdData
);
  logic runQ, roundQ, modeQ, snapQ;
  logic [FIELD_N-1:0] hit;
  logic ctrlWr;
  logic unusedBits;

  for (genvar gi = 0; gi < FIELD_N; gi++) begin : g_hit
    assign hit[gi] = wrEn && (addr == ADDR_W'(gi));
  end

  assign ctrlWr = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign unusedBits = ^{wrData[7], wrData[5:4], wrData[2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      roundQ <= 1'b0;
      modeQ  <= 1'b0;
      snapQ  <= 1'b0;
    end else if (ctrlWr) begin
      runQ   <= wrData[0];
      roundQ <= wrData[1];
      modeQ  <= wrData[3];
      snapQ  <= wrData[6];
    end else begin
      snapQ  <= 1'b0;
    end
  end

  always_comb begin
    strobes.fieldWr = hit;
    strobes.wrValue = wrData;
    strobes.step    = tick && runQ && !(|hit);
    strobes.snap    = snapQ;
  end

  assign runBit = runQ;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELD_N; i++) begin
      if (addr == ADDR_W'(i)) rdData = shadowFlat[i*BCD_W +: BCD_W];
    end
    if (addr == ADDR_W'(CTRL_ADDR))
      rdData = {1'b0, snapQ, 2'b00, modeQ, 1'b0, roundQ, runQ};
    if (addr == ADDR_W'(STATUS_ADDR))
      rdData = {6'd0, runQ, 1'b0};
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strobes,
  output logic [FIELD_N*BCD_W-1:0] liveFlat,
  output logic [FIELD_N*BCD_W-1:0] shadowFlat
);
  logic [BCD_W-1:0] liveQ   [FIELD_N];
  logic [BCD_W-1:0] shadowQ [FIELD_N];
  logic [BCD_W-1:0] lastV   [FIELD_N];
  logic [BCD_W-1:0] nextV   [FIELD_N];
  logic [FIELD_N-1:0] atEnd;
  logic [FIELD_N-1:0] adv;

  always_comb begin
    for (int i = 0; i < FIELD_N; i++) lastV[i] = fieldLastFixed(i);
    lastV[IDX_DAY] = monthLast(liveQ[IDX_MON], liveQ[IDX_YEAR]);
  end

  always_comb begin
    adv = '0;
    adv[IDX_SEC] = strobes.step;
    for (int i = 1; i <= IDX_YEAR; i++) adv[i] = adv[i-1] && atEnd[i-1];
    adv[IDX_WDAY] = adv[IDX_DAY];
  end

  for (genvar gi = 0; gi < FIELD_N; gi++) begin : g_field
    assign atEnd[gi] = liveQ[gi] >= lastV[gi];
    assign nextV[gi] = atEnd[gi] ? fieldFirst(gi) : bcdNext(liveQ[gi]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ[gi]   <= fieldFirst(gi);
        shadowQ[gi] <= fieldFirst(gi);
      end else begin
        if (strobes.fieldWr[gi])  liveQ[gi] <= strobes.wrValue;
        else if (adv[gi])         liveQ[gi] <= nextV[gi];
        if (strobes.snap)         shadowQ[gi] <= liveQ[gi];
      end
    end

    assign liveFlat[gi*BCD_W +: BCD_W]   = liveQ[gi];
    assign shadowFlat[gi*BCD_W +: BCD_W] = shadowQ[gi];
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 8,
  parameter int STATUS_ADDR = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  output logic [7:0]        rdData
);
  strobes_t strobes;
  logic runBit;
  logic [FIELD_N*BCD_W-1:0] liveFlat;
  logic [FIELD_N*BCD_W-1:0] shadowFlat;

  rtc_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .shadowFlat(shadowFlat), .strobes(strobes),
    .runBit(runBit), .rdData(rdData)
  );

  rtc_datapath dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .liveFlat(liveFlat), .shadowFlat(shadowFlat)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 8,
  parameter int STATUS_ADDR = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     tick,
  input logic [ADDR_W-1:0]        addr,
  input logic [7:0]               wrData,
  input logic                     wrEn,
  input logic [7:0]               rdData,
  input logic                     runBit,
  input strobes_t                 strobes,
  input logic [FIELD_N*BCD_W-1:0] liveFlat,
  input logic [FIELD_N*BCD_W-1:0] shadowFlat
);
  AST_STATUS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(STATUS_ADDR)) |-> (rdData == {6'd0, runBit, 1'b0})); // R6

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !(|strobes.fieldWr)) |=> (liveFlat == $past(liveFlat))); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0)) |=> (liveFlat[7:0] == $past(wrData))); // R8

  AST_SNAP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snap |-> $past(wrEn && addr == ADDR_W'(CTRL_ADDR) && wrData[6])); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.snap |=> (shadowFlat == $past(shadowFlat))); // R7

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && runBit && !(|strobes.fieldWr) && liveFlat[3:0] < 4'd9 && liveFlat[7:0] < 8'h59)
    |=> (liveFlat[7:0] == $past(liveFlat[7:0]) + 8'd1)); // R3
endmodule

bind bcd_rtc rtc_checker #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STATUS_ADDR(STATUS_ADDR)
) chk (
  .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrData(wrData),
  .wrEn(wrEn), .rdData(rdData), .runBit(runBit), .strobes(strobes),
  .liveFlat(liveFlat), .shadowFlat(shadowFlat)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  localparam int CTRL = 8;
  localparam int STAT = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0;
  logic [7:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int ms, mm, mh, md, mmo, my, mw;
  int ctrlM = 0;

  bcd_rtc uut (.clk(clk), .rstN(rstN), .tick(tick), .addr(addr),
               .wrData(wrData), .wrEn(wrEn), .rdData(rdData));

  always #10 clk = ~clk;

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] expTime();
    return {toBcd(mw), toBcd(my), toBcd(mmo), toBcd(md), toBcd(mh), toBcd(mm), toBcd(ms)};
  endfunction

  task automatic modelStep();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; md++; mw = (mw + 1) % 7;
          if (md > mdays(mmo, my)) begin
            md = 1; mmo++;
            if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    addr = 5'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == CTRL) ctrlM = d & 8'h0B;
  endtask

  task automatic rdReg(input int a, output logic [7:0] v);
    addr = 5'(a);
    #1 v = rdData;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (ctrlM[0]) modelStep();
    end
  endtask

  task automatic readRaw(output logic [55:0] t);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rdReg(i, v);
      t[i*8 +: 8] = v;
    end
  endtask

  task automatic snapRead(output logic [55:0] t);
    wrReg(CTRL, ctrlM | 8'h40);
    @(negedge clk);
    readRaw(t);
  endtask

  task automatic checkTime(input string tag);
    logic [55:0] t;
    snapRead(t);
    check(tag, t, expTime());
  endtask

  task automatic setTime(input int s, input int m, input int h, input int d,
                         input int mo, input int y, input int w);
    int keep;
    keep = ctrlM;
    wrReg(CTRL, keep & 8'h0A);
    wrReg(0, toBcd(s)); wrReg(1, toBcd(m)); wrReg(2, toBcd(h));
    wrReg(3, toBcd(d)); wrReg(4, toBcd(mo)); wrReg(5, toBcd(y)); wrReg(6, toBcd(w));
    wrReg(CTRL, keep | 1);
    ms = s; mm = m; mh = h; md = d; mmo = mo; my = y; mw = w;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [55:0] t;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
    readRaw(t);
    check("R1 reset time", t, expTime());
    rdReg(CTRL, v); check("R1 reset control", {48'd0, v}, 56'h0);
    rdReg(STAT, v); check("R1 reset status", {48'd0, v}, 56'h0);
    rdReg(7, v);    check("R2 unused 0x07", {48'd0, v}, 56'h0);
    rdReg(10, v);   check("R2 unused 0x0A", {48'd0, v}, 56'h0);
    rdReg(31, v);   check("R2 unused 0x1F", {48'd0, v}, 56'h0);

    tickN(3);
    checkTime("R6 stopped ignores ticks");
    wrReg(CTRL, 1);
    rdReg(STAT, v); check("R6 status running", {48'd0, v}, 56'h02);
    tickN(5);
    checkTime("R3 seconds count");

    setTime(59, 59, 23, 31, 12, 99, 6); tickN(1);
    checkTime("R4 R5 year end wrap");
    setTime(59, 59, 23, 28, 2, 24, 3); tickN(1);
    checkTime("R4 leap Feb 29");
    setTime(59, 59, 23, 29, 2, 24, 4); tickN(1);
    checkTime("R4 leap Mar 1");
    setTime(59, 59, 23, 28, 2, 23, 2); tickN(1);
    checkTime("R4 common Mar 1");
    setTime(59, 59, 23, 30, 4, 10, 1); tickN(1);
    checkTime("R4 Apr 30 rollover");
    setTime(59, 59, 10, 5, 7, 50, 2); tickN(2);
    checkTime("R3 minute hour carry");

    snapRead(t);
    tickN(2);
    rdReg(0, v); check("R7 latch stale", {48'd0, v}, {48'd0, t[7:0]});
    checkTime("R7 new snapshot");
    wrReg(CTRL, ctrlM | 8'h40);
    rdReg(CTRL, v); check("R7 snap bit pending", {48'd0, v}, 56'(ctrlM | 8'h40));
    @(negedge clk);
    rdReg(CTRL, v); check("R7 snap bit cleared", {48'd0, v}, 56'(ctrlM));

    @(negedge clk);
    addr = 5'd0; wrData = 8'h30; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0; ms = 30;
    checkTime("R8 write beats tick");
    wrReg(1, toBcd(42)); mm = 42;
    checkTime("R8 write while running");

    wrReg(CTRL, 8'h0B);
    rdReg(CTRL, v); check("R9 control storage", {48'd0, v}, 56'h0B);
    setTime(59, 59, 23, 15, 6, 33, 5); tickN(1);
    checkTime("R9 24h kept");
    setTime(14, 0, 12, 15, 6, 33, 5); tickN(3);
    checkTime("R9 no rounding");

    wrReg(STAT, 8'hFF);
    rdReg(STAT, v); check("R10 status write ignored", {48'd0, v}, 56'h02);
    wrReg(10, 8'h55);
    rdReg(10, v); check("R10 unused write ignored", {48'd0, v}, 56'h0);
    rdReg(CTRL, v); check("R10 control untouched", {48'd0, v}, 56'h0B);
    checkTime("R10 time untouched");

    for (int it = 0; it < 150; it++) begin
      int s, m, h, d, mo, y, w;
      bit edgey;
      edgey = ($urandom % 2) == 1;
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      d  = edgey ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
      h  = edgey ? 23 : $urandom % 24;
      m  = edgey ? 59 : $urandom % 60;
      s  = edgey ? 57 + $urandom % 3 : $urandom % 60;
      w  = $urandom % 7;
      setTime(s, m, h, d, mo, y, w);
      tickN(1 + $urandom % 4);
      checkTime("R3 R4 R5 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule